// File: doc/BRIEF.md
# Almost Montgomery Inverse Engine

This block takes an odd prime modulus p whose top bit is set (2^(N-1) ≤ p < 2^N) and an operand a in [1, p−1]. It produces the almost Montgomery inverse r = a^-1·2^k mod p, together with the number of iterations k that the reduction loop needed. The whole width is processed in parallel. Each iteration of the binary extended-Euclid style loop takes one clock. One further clock applies the final range fix-up.

A caller waits for `ready`, presents `opA` and `modP`, and pulses `start` for one cycle. The engine loads its working registers and iterates until its internal v value reaches zero. It then raises `done` for one cycle. `result` and `kCount` keep their values until the next accepted start. A later stage can turn the pair (r, k) into a Montgomery-domain inverse by dividing out the surplus power of two.

Top module: `almost_inverse_unit`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0, and `result` and `kCount` are 0. `ready` is 1 whenever the engine is idle, including the cycle in which `done` is 1.
- R2: A `start` sampled high while `ready` is 1 loads u = p, v = a, r = 0, s = 1 and k = 0, and `ready` drops on the next cycle.
- R3: In each iteration, an even u is halved and s is doubled. Otherwise, an even v is halved and r is doubled. Otherwise both differences u−v and v−u are formed along with r+s. If u > v (v−u borrows), then u becomes (u−v)/2, r becomes r+s and s doubles. In every other case, v becomes (v−u)/2, s becomes r+s and r doubles.
- R4: k rises by exactly one per iteration, and the loop stops once v is zero. `done` is 1 in the cycle that follows k+2 rising edges, counting the edge that sampled `start` as the first.
- R5: In the fix-up, p−r and 2p−r are formed together. p−r is returned when it does not borrow, and 2p−r otherwise. The returned value lies in [1, p−1] and satisfies result·a ≡ 2^k (mod p).
- R6: The returned k satisfies N ≤ k ≤ 2N.
- R7: `done` is high for exactly one cycle. `result` and `kCount` stay stable from that point until the next accepted start, whatever `opA` and `modP` do.
- R8: A `start` pulse that arrives while `ready` is 0 is ignored and does not alter the operation in progress or its outcome.
- R9: The internal r and s registers are one bit wider than N, and r+s and 2p−r never carry out of the N+1 and N bit result fields respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; honoured only while `ready` is 1 |
| opA | input | N_BITS | Operand a, in [1, p−1] |
| modP | input | N_BITS | Odd prime modulus p with its top bit set |
| ready | output | 1 | Engine idle and able to accept `start` |
| done | output | 1 | One-cycle pulse when `result` and `kCount` are fresh |
| result | output | N_BITS | a^-1·2^k mod p |
| kCount | output | $clog2(2·N_BITS+1) | Iteration count k |

## Verification
A wrong branch choice or a corrupted u, v, r or s register shows up at the ports in one of two ways. It can shift the iteration count, which moves the `done` pulse away from the cycle the reference model predicts and changes `kCount`. It can also leave a result that fails result·a ≡ 2^k (mod p). A per-clock comparison of `ready` and `done` therefore catches a timing fault within one cycle of the predicted completion. A value fault is caught at the `done` cycle through both the exact result and the independent modular identity. Holds and ignored starts are checked by disturbing the inputs and then watching the outputs in the idle cycles that follow.

// File: rtl/amiv_pkg.sv
package amiv_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;    // capture operands, init working registers
    logic step;    // perform one reduction iteration
    logic finish;  // apply range fix-up, latch result
  } ctlStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } engState_t;

endpackage

// File: rtl/amiv_ctrl.sv
module amiv_ctrl
  import amiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        vZero,
  output ctlStrobes_t ctl,
  output logic        ready,
  output logic        done
);

  engState_t state, stateNext;

  always_comb begin
    ctl.load   = (state == ST_IDLE) && start;
    ctl.step   = (state == ST_RUN) && !vZero;
    ctl.finish = (state == ST_RUN) && vZero;
    stateNext  = state;
    if (ctl.load)   stateNext = ST_RUN;
    if (ctl.finish) stateNext = ST_IDLE;
  end

  assign ready = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= ctl.finish;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && start && !vZero) |=> !ready);

  // R1
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

endmodule

// File: rtl/amiv_datapath.sv
module amiv_datapath
  import amiv_pkg::*;
#(
  parameter int N  = 16,
  parameter int KW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctlStrobes_t   ctl,
  input  logic [N-1:0]  opA,
  input  logic [N-1:0]  modP,
  output logic          vZero,
  output logic [N-1:0]  result,
  output logic [KW-1:0] kCount
);

  localparam int RW = N + 1;   // width of r and s
  localparam int FW = N + 2;   // width of fix-up arithmetic
  localparam logic [KW-1:0] K_MIN = KW'(N);
  localparam logic [KW-1:0] K_MAX = KW'(2 * N);

  logic [N-1:0]  uReg, vReg, pReg, resReg;
  logic [RW-1:0] rReg, sReg;
  logic [KW-1:0] kReg;

  // Parallel comparison: both differences at once
  logic [N:0]    diffUV, diffVU;
  logic          uGreater;
  logic [FW-1:0] sumRS;

  assign diffUV   = {1'b0, uReg} - {1'b0, vReg};
  assign diffVU   = {1'b0, vReg} - {1'b0, uReg};
  assign uGreater = diffVU[N] & ~diffUV[N];
  assign sumRS    = {1'b0, rReg} + {1'b0, sReg};
  assign vZero    = (vReg == '0);

  // Range fix-up: p - r and 2p - r formed together
  logic [FW-1:0] pExt, rExt, diffP, diff2P, fixWide;
  logic          borrowP;

  assign pExt    = {2'b00, pReg};
  assign rExt    = {1'b0, rReg};
  assign diffP   = pExt - rExt;
  assign diff2P  = (pExt << 1) - rExt;
  assign borrowP = diffP[FW-1];
  assign fixWide = borrowP ? diff2P : diffP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uReg   <= '0;
      vReg   <= '0;
      pReg   <= '0;
      rReg   <= '0;
      sReg   <= '0;
      kReg   <= '0;
      resReg <= '0;
    end else if (ctl.load) begin
      uReg <= modP;
      vReg <= opA;
      pReg <= modP;
      rReg <= '0;
      sReg <= RW'(1);
      kReg <= '0;
    end else if (ctl.step) begin
      kReg <= kReg + 1'b1;
      if (!uReg[0]) begin
        uReg <= uReg >> 1;
        sReg <= sReg << 1;
      end else if (!vReg[0]) begin
        vReg <= vReg >> 1;
        rReg <= rReg << 1;
      end else if (uGreater) begin
        uReg <= {1'b0, diffUV[N-1:1]};
        rReg <= sumRS[RW-1:0];
        sReg <= sReg << 1;
      end else begin
        vReg <= {1'b0, diffVU[N-1:1]};
        sReg <= sumRS[RW-1:0];
        rReg <= rReg << 1;
      end
    end else if (ctl.finish) begin
      resReg <= fixWide[N-1:0];
    end
  end

  assign result = resReg;
  assign kCount = kReg;

  // R2
  load_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |=> (uReg == $past(modP) && vReg == $past(opA)
                  && rReg == '0 && sReg == RW'(1) && kReg == '0));

  // R4
  k_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.step |=> kReg == $past(kReg) + 1'b1);

  // R6
  k_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.finish |=> (kReg >= K_MIN && kReg <= K_MAX));

  // R5
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.finish |=> (resReg != '0 && resReg < pReg));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.step |-> (sumRS[FW-1] == 1'b0));

  // R9
  fix_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.finish |-> (fixWide[FW-1:N] == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.load && !ctl.finish && !ctl.step) |=> ($stable(resReg) && $stable(kReg)));

endmodule

// File: rtl/almost_inverse_unit.sv
module almost_inverse_unit
  import amiv_pkg::*;
#(
  parameter int N_BITS = 16,
  localparam int KW    = $clog2(2 * N_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N_BITS-1:0] opA,
  input  logic [N_BITS-1:0] modP,
  output logic              ready,
  output logic              done,
  output logic [N_BITS-1:0] result,
  output logic [KW-1:0]     kCount
);

  ctlStrobes_t ctl;
  logic        vZero;

  amiv_ctrl i_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .vZero (vZero),
    .ctl   (ctl),
    .ready (ready),
    .done  (done)
  );

  amiv_datapath #(
    .N  (N_BITS),
    .KW (KW)
  ) i_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .opA    (opA),
    .modP   (modP),
    .vZero  (vZero),
    .result (result),
    .kCount (kCount)
  );

endmodule

// File: tb/test_almost_inverse_unit.sv
module test_almost_inverse_unit;

  localparam int N  = 16;
  localparam int KW = $clog2(2 * N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  opA = '0;
  logic [N-1:0]  modP = '0;
  logic          ready, done;
  logic [N-1:0]  result;
  logic [KW-1:0] kCount;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  almost_inverse_unit #(.N_BITS(N)) i_almost_inverse_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opA(opA), .modP(modP),
    .ready(ready), .done(done), .result(result), .kCount(kCount)
  );

  task automatic check(string req, longint actual, longint expected, string what);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  function automatic bit isPrime(int x);
    if (x < 2 || x % 2 == 0) return (x == 2);
    for (int d = 3; d * d <= x; d += 2)
      if (x % d == 0) return 0;
    return 1;
  endfunction

  // Behavioural model of the requirements R3/R5
  task automatic refModel(input longint p, input longint a,
                          output int k, output longint res);
    longint u, v, r, s;
    u = p; v = a; r = 0; s = 1; k = 0;
    while (v != 0) begin
      if (u % 2 == 0) begin u = u / 2; s = s * 2; end
      else if (v % 2 == 0) begin v = v / 2; r = r * 2; end
      else if (u > v) begin u = (u - v) / 2; r = r + s; s = s * 2; end
      else begin v = (v - u) / 2; s = s + r; r = r * 2; end
      k++;
    end
    res = (p - r >= 0) ? p - r : 2 * p - r;
  endtask

  function automatic longint pow2Mod(int k, longint p);
    longint x = 1;
    for (int i = 0; i < k; i++) x = (x * 2) % p;
    return x;
  endfunction

  task automatic runOne(int p, int a, bit poke);
    int ek; longint er; longint heldRes; longint heldK;
    refModel(p, a, ek, er);
    @(negedge clk);
    check("R1", ready, 1, "ready before start");
    opA = a[N-1:0]; modP = p[N-1:0]; start = 1'b1;
    for (int m = 1; m <= ek + 2; m++) begin
      @(negedge clk);
      start = 1'b0;
      // R4 cycle-accurate handshake timing
      check("R4", ready, (m >= ek + 2), "ready timing");
      check("R4", done,  (m == ek + 2), "done timing");
      if (poke && m == 3) begin
        // R8: start while busy with other operands
        start = 1'b1; opA = 16'd3; modP = 16'd32771;
      end
    end
    // R3/R5 exact value, R5 modular identity, R6 range
    check("R3", result, er, "result value");
    check("R4", kCount, ek, "k value");
    check("R5", (longint'(result) * a) % p, pow2Mod(int'(kCount), p), "result*a vs 2^k");
    check("R5", (result >= 1 && result < p), 1, "result range");
    check("R6", (kCount >= N && kCount <= 2 * N), 1, "k range");
    if (poke) check("R8", result, er, "busy start ignored");
    heldRes = result; heldK = kCount;
    opA = ~opA; modP = 16'd40009;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7", done, 0, "done single pulse");
      check("R7", result, heldRes, "result hold");
      check("R7", kCount, heldK, "k hold");
    end
  endtask

  initial begin
    int p, a, pMin, pMax;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", ready, 1, "reset ready");
    check("R1", done, 0, "reset done");
    check("R1", result, 0, "reset result");
    check("R1", kCount, 0, "reset k");
    rst_n = 1'b1;
    @(negedge clk);
    // R2: first start loads from defined operands; boundary primes
    pMin = 32768; while (!isPrime(pMin)) pMin++;
    pMax = 65535; while (!isPrime(pMax)) pMax--;
    runOne(pMin, 1, 0);
    runOne(pMin, pMin - 1, 0);
    runOne(pMax, 1, 0);
    runOne(pMax, pMax - 1, 1);
    runOne(pMax, 2, 0);
    runOne(pMin, (pMin - 1) / 2, 1);
    for (int t = 0; t < 60; t++) begin
      p = int'($urandom_range(32768, 65535)) | 1;
      while (!isPrime(p)) p = (p + 2 > 65535) ? 32769 : p + 2;
      a = int'($urandom_range(1, p - 1));
      runOne(p, a, (t % 4) == 0);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule